// File: doc/BRIEF.md
# Serial ADC Readout Controller

This block sits on the host side of a three-wire link to a 12-bit successive-approximation converter. It drives an active-low chip select and a generated serial clock, and it reads the converter's serial data line. Pulling chip select low samples the analog input and starts the conversion. The conversion itself is paced by the 16 serial clock cycles that follow. Each frame returns the result of the sample taken at its own chip-select fall, so there is no pipeline latency.

A frame is 16 bits, sent MSB first. The first four bits are a zero header. The remaining twelve bits are the unsigned result in straight binary. The controller creates the clock with a programmable half period, counted in system clocks. It waits a programmable setup delay between the chip-select fall and the serial clock, and it keeps chip select high for a programmable quiet gap between frames. At the end of a frame it shifts the result out, sets a flag if the header was not all zeros, and pulses a valid strobe for one cycle.

A frame can be started by a request pulse, or it can be launched repeatedly at a programmed rate. A request that arrives while a frame or its quiet gap is running is kept and served once the gap is over.

The controller has four states:
- IDLE: chip select is high and the serial clock is high.
- SETUP: chip select is low and the setup delay is being counted.
- SHIFT: the 32 serial clock edges are generated.
- QUIET: chip select is high and the quiet gap is being counted.

It has five transitions:
- IDLE to SETUP: a kept request or a rate-due condition launches a frame.
- SETUP to SHIFT: the setup delay has been counted.
- SHIFT to QUIET: the 32nd serial clock edge, which is the 16th rise.
- QUIET to IDLE: the quiet gap has been counted.
- Each state stays where it is when its condition is not met.

Top module: `adc_frame_ctrl`

## Requirements
- R1: After reset, cs_n_o is 1, sclk_o is 1 and valid_o is 0.
- R2: In each frame, cs_n_o stays low for exactly max(setup_cycles_i,1) + 32*H clock cycles, where H = max(half_period_i,1). During that time sclk_o falls exactly 16 times, and every sclk_o phase after the first fall lasts exactly H cycles.
- R3: sdata_i is sampled in the clock cycle in which sclk_o falls. The 16 samples form a word with the first sample as bit 15. sample_o is bits 11..0 of that word, read as an unsigned straight-binary value.
- R4: frame_err_o is 1 exactly when any of word bits 15..12 (the first four samples) is 1.
- R5: valid_o is high for one cycle only, in the same cycle that cs_n_o returns high. sample_o and frame_err_o hold their values until the next valid_o.
- R6: The first fall of sclk_o comes exactly max(setup_cycles_i,1) + H cycles after cs_n_o falls.
- R7: Between frames, cs_n_o stays high for at least max(quiet_cycles_i,1) + 1 cycles. A frame only ends in the QUIET state with cs_n_o high.
- R8: sclk_o is 1 whenever cs_n_o is 1.
- R9: From IDLE, cs_n_o falls on the second clock edge after start_i is sampled high. A start_i seen during SETUP, SHIFT or QUIET is kept. It launches exactly one more frame, whose cs_n_o fall comes max(quiet,1) + 1 cycles after the previous frame ends.
- R10: With auto_en_i set, successive cs_n_o falls are spaced by max(max(rate_cycles_i,1), max(setup,1) + 32*H + max(quiet,1) + 1) cycles.
- R11: sdata_i has no effect on sample_o or frame_err_o outside the 16 sampling cycles, including while cs_n_o is high and after the 16th sclk_o fall.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Request one frame; kept if busy |
| auto_en_i | input | 1 | Launch frames repeatedly at the programmed rate |
| half_period_i | input | DIV_W | Serial clock half period in clock cycles (0 is treated as 1) |
| setup_cycles_i | input | CNT_W | Cycles from the cs_n_o fall to the start of clocking (0 is treated as 1) |
| quiet_cycles_i | input | CNT_W | Quiet gap in clock cycles after a frame (0 is treated as 1) |
| rate_cycles_i | input | CNT_W | Auto-mode spacing between cs_n_o falls |
| sdata_i | input | 1 | Serial data from the converter |
| cs_n_o | output | 1 | Active-low chip select |
| sclk_o | output | 1 | Serial clock; idles high |
| sample_o | output | DATA_W | Last conversion result |
| frame_err_o | output | 1 | The header of the last frame was not all zeros |
| valid_o | output | 1 | One-cycle strobe for a new result |

## Verification
A start request can land in the same cycle as the end of a frame. In that cycle the valid strobe is high and the controller is entering the quiet gap. The bench raises start_i while valid_o is high. The request must be kept, and the next chip-select fall must come exactly quiet+1 cycles after the frame ended. Two further cases are checked in the same way: a request made in the middle of a frame, and auto-rate triggers with a period shorter than one frame. In each case the bench judges the result by the exact spacing of the chip-select falls and by the number of frames, with every result matched against the scoreboard queue.

// File: rtl/adc_frame_pkg.sv
package adc_frame_pkg;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_SETUP,
        ST_SHIFT,
        ST_QUIET
    } frame_state_t;

endpackage

// File: rtl/adc_sclk_tick.sv
module adc_sclk_tick #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run_i,
    input  logic [DIV_W-1:0] half_i,
    output logic             tick_o
);
    logic [DIV_W-1:0] phase_q;
    logic [DIV_W-1:0] half_lim;

    assign half_lim = (half_i == '0) ? DIV_W'(1) : half_i;
    assign tick_o   = run_i && (phase_q == half_lim - DIV_W'(1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            phase_q <= '0;
        end else if (!run_i || tick_o) begin
            phase_q <= '0;
        end else begin
            phase_q <= phase_q + DIV_W'(1);
        end
    end
endmodule

// File: rtl/adc_frame_shift.sv
module adc_frame_shift #(
    parameter int FRAME_W = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               shift_en_i,
    input  logic               bit_i,
    output logic [FRAME_W-1:0] frame_o
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            frame_o <= '0;
        end else if (shift_en_i) begin
            frame_o <= {frame_o[FRAME_W-2:0], bit_i};
        end
    end
endmodule

// File: rtl/adc_rate_timer.sv
module adc_rate_timer #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             launch_i,
    input  logic             enable_i,
    input  logic [CNT_W-1:0] period_i,
    output logic             due_o
);
    logic [CNT_W-1:0] since_q;
    logic [CNT_W-1:0] period_lim;

    assign period_lim = (period_i == '0) ? CNT_W'(1) : period_i;
    assign due_o      = enable_i && (since_q >= period_lim - CNT_W'(1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            since_q <= '0;
        end else if (launch_i) begin
            since_q <= '0;
        end else if (since_q != '1) begin
            since_q <= since_q + CNT_W'(1);
        end
    end
endmodule

// File: rtl/adc_frame_ctrl.sv
module adc_frame_ctrl
    import adc_frame_pkg::*;
#(
    parameter int DIV_W  = 8,
    parameter int CNT_W  = 16,
    parameter int DATA_W = 12,
    parameter int HDR_W  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic              auto_en_i,
    input  logic [DIV_W-1:0]  half_period_i,
    input  logic [CNT_W-1:0]  setup_cycles_i,
    input  logic [CNT_W-1:0]  quiet_cycles_i,
    input  logic [CNT_W-1:0]  rate_cycles_i,
    input  logic              sdata_i,
    output logic              cs_n_o,
    output logic              sclk_o,
    output logic [DATA_W-1:0] sample_o,
    output logic              frame_err_o,
    output logic              valid_o
);
    localparam int FRAME_W = DATA_W + HDR_W;
    localparam int EDGE_N  = 2 * FRAME_W;
    localparam int EC_W    = $clog2(EDGE_N);

    frame_state_t       state_q, state_d;
    logic [CNT_W-1:0]   gap_q;
    logic [EC_W-1:0]    edge_q;
    logic               pend_q;
    logic               tick;
    logic               due;
    logic               launch;
    logic               last_edge;
    logic               sample_en;
    logic               setup_done;
    logic               quiet_done;
    logic [CNT_W-1:0]   setup_lim;
    logic [CNT_W-1:0]   quiet_lim;
    logic [FRAME_W-1:0] frame;

    assign setup_lim  = (setup_cycles_i == '0) ? CNT_W'(1) : setup_cycles_i;
    assign quiet_lim  = (quiet_cycles_i == '0) ? CNT_W'(1) : quiet_cycles_i;
    assign setup_done = (gap_q == setup_lim - CNT_W'(1));
    assign quiet_done = (gap_q == quiet_lim - CNT_W'(1));
    assign launch     = (state_q == ST_IDLE) && (pend_q || due);
    assign last_edge  = (state_q == ST_SHIFT) && tick && (edge_q == EC_W'(EDGE_N - 1));
    assign sample_en  = (state_q == ST_SHIFT) && tick && !edge_q[0];

    adc_sclk_tick #(.DIV_W(DIV_W)) u_tick (
        .clk    (clk),
        .rst_n  (rst_n),
        .run_i  (state_q == ST_SHIFT),
        .half_i (half_period_i),
        .tick_o (tick)
    );

    adc_frame_shift #(.FRAME_W(FRAME_W)) u_shift (
        .clk        (clk),
        .rst_n      (rst_n),
        .shift_en_i (sample_en),
        .bit_i      (sdata_i),
        .frame_o    (frame)
    );

    adc_rate_timer #(.CNT_W(CNT_W)) u_rate (
        .clk      (clk),
        .rst_n    (rst_n),
        .launch_i (launch),
        .enable_i (auto_en_i),
        .period_i (rate_cycles_i),
        .due_o    (due)
    );

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (launch)     state_d = ST_SETUP;
            ST_SETUP: if (setup_done) state_d = ST_SHIFT;
            ST_SHIFT: if (last_edge)  state_d = ST_QUIET;
            ST_QUIET: if (quiet_done) state_d = ST_IDLE;
        endcase
    end

    // state register with its counters and the kept request
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            gap_q   <= '0;
            edge_q  <= '0;
            pend_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            pend_q  <= (pend_q && !launch) || start_i;
            if (state_d != state_q) begin
                gap_q <= '0;
            end else if (state_q == ST_SETUP || state_q == ST_QUIET) begin
                gap_q <= gap_q + CNT_W'(1);
            end
            if (state_q != ST_SHIFT) begin
                edge_q <= '0;
            end else if (tick) begin
                edge_q <= edge_q + EC_W'(1);
            end
        end
    end

    // registered outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cs_n_o      <= 1'b1;
            sclk_o      <= 1'b1;
            sample_o    <= '0;
            frame_err_o <= 1'b0;
            valid_o     <= 1'b0;
        end else begin
            cs_n_o  <= !(state_d == ST_SETUP || state_d == ST_SHIFT);
            valid_o <= last_edge;
            if (state_d != ST_SHIFT) begin
                sclk_o <= 1'b1;
            end else if (tick) begin
                sclk_o <= !sclk_o;
            end
            if (last_edge) begin
                sample_o    <= frame[DATA_W-1:0];
                frame_err_o <= |frame[FRAME_W-1 -: HDR_W];
            end
        end
    end

    a_r8_sclk_idle_high: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n_o |-> sclk_o);

    a_r5_valid_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |=> !valid_o);

    a_r5_valid_at_cs_rise: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |-> (cs_n_o && !$past(cs_n_o)));

    a_r9_launch_from_idle: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(cs_n_o) |-> ($past(state_q) == ST_IDLE));

    a_r7_quiet_cs_high: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_QUIET) |-> cs_n_o);

endmodule

// File: tb/sim_adc_frame_ctrl.sv
module sim_adc_frame_ctrl;
    localparam int H = 2;
    localparam int S = 3;
    localparam int Q = 4;
    localparam int FRAME_LOW = S + 32 * H;
    localparam int MIN_SPACE = FRAME_LOW + Q + 1;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic        auto_en_i = 1'b0;
    logic [7:0]  half_period_i = 8'(H);
    logic [15:0] setup_cycles_i = 16'(S);
    logic [15:0] quiet_cycles_i = 16'(Q);
    logic [15:0] rate_cycles_i = 16'd0;
    logic        sdata_i = 1'b1;
    logic        cs_n_o, sclk_o, frame_err_o, valid_o;
    logic [11:0] sample_o;

    int nchk = 0, nfail = 0;
    logic [12:0] exp_q[$];
    logic [15:0] dev_q[$];

    always #10 clk = ~clk;

    adc_frame_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .auto_en_i(auto_en_i),
        .half_period_i(half_period_i), .setup_cycles_i(setup_cycles_i),
        .quiet_cycles_i(quiet_cycles_i), .rate_cycles_i(rate_cycles_i),
        .sdata_i(sdata_i), .cs_n_o(cs_n_o), .sclk_o(sclk_o),
        .sample_o(sample_o), .frame_err_o(frame_err_o), .valid_o(valid_o)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic send(input logic [15:0] w);
        dev_q.push_back(w);
        exp_q.push_back({|w[15:12], w[11:0]});
    endtask

    // converter model: data changes after each serial clock fall
    logic [15:0] cur = '0;
    int          idx = 0;
    logic        d_prev_cs = 1'b1, d_prev_sclk = 1'b1;
    always @(negedge clk) begin
        if (rst_n) begin
            if (d_prev_cs && !cs_n_o) begin
                cur = (dev_q.size() > 0) ? dev_q.pop_front() : 16'hFFFF;
                idx = 0;
                sdata_i = cur[15];
            end else if (!cs_n_o && d_prev_sclk && !sclk_o) begin
                idx++;
                sdata_i = (idx < 16) ? cur[15 - idx] : ~sdata_i;
            end else if (cs_n_o || idx >= 16) begin
                sdata_i = ~sdata_i;   // noise outside the frame (R11)
            end
            d_prev_cs = cs_n_o;
            d_prev_sclk = sclk_o;
        end
    end

    // monitor and scoreboard
    int   cyc = 0, fall_cyc = 0, rise_cyc = 0, tog_cyc = 0;
    int   nfall = 0, bad_phase = 0, nframes = 0, last_spacing = 0;
    bit   have_fall = 0, have_rise = 0;
    logic m_prev_cs = 1'b1, m_prev_sclk = 1'b1, m_prev_valid = 1'b0;
    logic [12:0] exp_item;
    always @(negedge clk) begin
        if (rst_n) begin
            cyc++;
            if (m_prev_cs && !cs_n_o) begin
                if (have_fall) last_spacing = cyc - fall_cyc;
                if (have_rise) check(cyc - rise_cyc >= Q + 1, "R7 quiet gap", cyc - rise_cyc, Q + 1);
                fall_cyc = cyc; tog_cyc = cyc; have_fall = 1;
                nfall = 0; bad_phase = 0; nframes++;
            end
            if ((!cs_n_o || !m_prev_cs) && (sclk_o != m_prev_sclk)) begin
                if (m_prev_sclk && !sclk_o) begin
                    nfall++;
                    if (nfall == 1) check(cyc - fall_cyc == S + H, "R6 setup to first fall", cyc - fall_cyc, S + H);
                    else if (cyc - tog_cyc != H) bad_phase++;
                end else if (cyc - tog_cyc != H) begin
                    bad_phase++;
                end
                tog_cyc = cyc;
            end
            if (!m_prev_cs && cs_n_o) begin
                rise_cyc = cyc; have_rise = 1;
                check(cyc - fall_cyc == FRAME_LOW, "R2 cs low length", cyc - fall_cyc, FRAME_LOW);
                check(nfall == 16, "R2 sclk falls", nfall, 16);
                check(bad_phase == 0, "R2 phase length", bad_phase, 0);
                check(sclk_o == 1'b1, "R8 sclk high with cs high", sclk_o, 1);
            end
            if (valid_o) begin
                check(!m_prev_valid && m_prev_cs == 1'b0 && cs_n_o,
                      "R5 valid single and at cs rise", m_prev_valid, 0);
                if (exp_q.size() == 0) begin
                    check(0, "R3 unexpected result", sample_o, -1);
                end else begin
                    exp_item = exp_q.pop_front();
                    check(sample_o == exp_item[11:0], "R3 result", sample_o, exp_item[11:0]);
                    check(frame_err_o == exp_item[12], "R4 header flag", frame_err_o, exp_item[12]);
                end
            end
            m_prev_cs = cs_n_o; m_prev_sclk = sclk_o; m_prev_valid = valid_o;
        end
    end

    task automatic wait_empty();
        while (exp_q.size() != 0) @(negedge clk);
        repeat (3) @(negedge clk);
    endtask

    task automatic pulse_start(output int lat);
        @(posedge clk); #1 start_i = 1'b1;
        @(posedge clk); #1 start_i = 1'b0;
        lat = 0;
        while (cs_n_o) begin @(negedge clk); lat++; end
    endtask

    task automatic wait_frames(input int target);
        while (nframes < target) @(negedge clk);
    endtask

    bit done = 0;
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            nfail++; nchk++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
            $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
            $finish;
        end
    end

    initial begin
        int lat;
        int base;
        repeat (4) @(negedge clk);
        check(cs_n_o == 1'b1, "R1 cs idle in reset", cs_n_o, 1);
        check(sclk_o == 1'b1, "R1 sclk idle in reset", sclk_o, 1);
        @(posedge clk); #1 rst_n = 1'b1;
        repeat (5) @(negedge clk);
        check(cs_n_o == 1'b1 && sclk_o == 1'b1, "R1 idle after reset", {cs_n_o, sclk_o}, 3);
        check(valid_o == 1'b0, "R1 valid low", valid_o, 0);

        // manual frames: mixed values, then header faults
        send(16'h0A5C);
        pulse_start(lat);
        check(lat == 2, "R9 idle launch latency", lat, 2);
        wait_empty();
        begin
            logic [15:0] words[5] = '{16'h0FFF, 16'h0000, 16'h0123, 16'h8456, 16'h1001};
            foreach (words[i]) begin
                send(words[i]);
                pulse_start(lat);
                wait_empty();
                repeat (5) @(negedge clk);
            end
        end
        // R11 and R5: noise while idle must not disturb the held result
        repeat (40) @(negedge clk);
        check(sample_o == 12'h001, "R11 result held under noise", sample_o, 12'h001);
        check(frame_err_o == 1'b1, "R5 flag held", frame_err_o, 1);

        // R9: request mid-frame, then a request coinciding with the valid strobe
        base = nframes;
        send(16'h0321); send(16'h0654); send(16'h0987);
        pulse_start(lat);
        repeat (20) @(negedge clk);
        @(posedge clk); #1 start_i = 1'b1;
        @(posedge clk); #1 start_i = 1'b0;
        wait_frames(base + 2);
        check(last_spacing == MIN_SPACE, "R9 held request spacing", last_spacing, MIN_SPACE);
        while (!valid_o) @(negedge clk);
        start_i = 1'b1;
        @(posedge clk); #1 start_i = 1'b0;
        wait_frames(base + 3);
        check(last_spacing == MIN_SPACE, "R9 request with valid spacing", last_spacing, MIN_SPACE);
        wait_empty();
        repeat (150) @(negedge clk);
        check(nframes == base + 3, "R9 exactly one frame per request", nframes - base, 3);

        // R10: auto rate longer than a frame
        base = nframes;
        rate_cycles_i = 16'd100;
        send(16'h0111); send(16'h0222); send(16'h0333);
        auto_en_i = 1'b1;
        wait_frames(base + 3);
        auto_en_i = 1'b0;
        check(last_spacing == 100, "R10 auto spacing at rate", last_spacing, 100);
        wait_empty();

        // R10: auto rate shorter than a frame
        base = nframes;
        rate_cycles_i = 16'd20;
        send(16'h0444); send(16'h0555); send(16'h0666);
        auto_en_i = 1'b1;
        wait_frames(base + 3);
        auto_en_i = 1'b0;
        check(last_spacing == MIN_SPACE, "R10 auto spacing clamped", last_spacing, MIN_SPACE);
        wait_empty();
        repeat (150) @(negedge clk);
        check(nframes == base + 3, "R10 no frame after auto off", nframes - base, 3);

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
        $finish;
    end
endmodule